// File: doc/BRIEF.md
# Ping-Pong Transform Buffer Controller

This block sits between a sample source, a result sink and a transform engine. Samples arrive on an input strobe that is asynchronous to the system clock. They are written into a circular workspace that holds two transform blocks. While the engine works on one block, the next one fills. The engine reads its block through a read port. The controller adds the block's base address, so the engine only supplies an offset. When a block is complete and the engine is idle, the controller issues a one-cycle start pulse and reports the block's base address.

Results go to a separate output store. The engine writes it once the store is free and signals completion. The results are then drained, one word per rising edge of a second asynchronous strobe, while loading and transforming carry on. Two enables gate the input and output transfers.

A rate select lets one shared strobe drive both directions. In that case the input takes every second or every fourth output strobe edge. An overlap count lets each new block reuse the last samples of the previous block, so only the remainder has to be loaded. Samples are stored as they arrive and are not windowed. Any window is applied by the engine when it first reads the block, which keeps reused samples correct.

Top module: `ppb_xform_buf_ctrl`

## Requirements
- R1: After reset, in_rdy=1, out_avail=0, ob_free=1, eng_start=0, eng_wait=0 and eng_base=0.
- R2: Each rising edge of the selected input strobe is synchronised with two flops. If in_en and in_rdy are high, it stores in_data at the write position, and the write position then advances by one modulo 2*N_PTS.
- R3: An input strobe edge while in_en is low, or while in_rdy is low, stores nothing and leaves the fill state unchanged.
- R4: The start condition is that N_PTS samples are held from the pending block start and no transform is active. When it is met, eng_start pulses for exactly one cycle and eng_base gives that block start. The next block start then moves forward by N_PTS minus overlap, and the overlap samples count toward the next block.
- R5: While a transform is active (from eng_start until eng_done), no new eng_start is issued. If the next block is complete during that time, eng_wait=1 and in_rdy=0.
- R6: One cycle after eng_rd_addr is applied, eng_rd_data holds the sample at workspace position (eng_base + eng_rd_addr) mod 2*N_PTS.
- R7: rate_sel=0 takes samples on in_stb. rate_sel=1 takes them on every 2nd rising edge of out_stb, and rate_sel=2 or 3 on every 4th, counting from reset. In these three shared modes in_stb is ignored.
- R8: Results written through eng_res_we/eng_res_addr/eng_res_data and followed by an eng_done pulse make out_avail=1 and ob_free=0.
- R9: Each out_stb rising edge with out_en=1 and out_avail=1 puts the next result on out_data, in address order 0..N_PTS-1, valid from the cycle after the synchronised edge. After the last one, out_avail=0 and ob_free=1.
- R10: out_stb edges while out_en=0 consume no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | 0: own input strobe; 1: shared strobe /2; 2,3: shared strobe /4 |
| overlap | input | AW | Samples reused from the previous block (0..N_PTS-1) |
| in_stb | input | 1 | Asynchronous input sample strobe |
| in_en | input | 1 | Input transfer enable |
| in_data | input | DW | Input sample, stable around the strobe edge |
| in_rdy | output | 1 | Workspace can accept a sample |
| out_stb | input | 1 | Asynchronous output strobe (also shared input strobe) |
| out_en | input | 1 | Output transfer enable |
| out_data | output | DW | Drained result word |
| out_avail | output | 1 | Output store holds undrained results |
| eng_start | output | 1 | One-cycle transform start |
| eng_base | output | AW+1 | Workspace base of the block being transformed |
| eng_wait | output | 1 | Next block complete but engine still busy |
| eng_done | input | 1 | Engine finished and results are written |
| eng_rd_addr | input | AW | Engine read offset within its block |
| eng_rd_data | output | DW | Workspace word, one cycle after the offset |
| eng_res_we | input | 1 | Result write strobe |
| eng_res_addr | input | AW | Result write address |
| eng_res_data | input | DW | Result word |
| ob_free | output | 1 | Output store may be written |

## Verification
Every cycle, the assertions check a few rules. The write position does not move while the pending block is full. Starts are single pulses, and none is issued while a transform runs. A shared-strobe sample resets the rate divider. The drain index moves only on an enabled output edge, and the engine never writes a result while the store holds undrained data. Other behaviour can only be shown by the bench scenarios: block contents under changing overlap counts, the exact 1-in-2 and 1-in-4 selection of shared-strobe edges, ignored edges when in_en is low or when running in shared mode, and the order of drained results.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
package ppb_pkg;
  // Source of the input sample events
  typedef enum logic [1:0] {
    RATE_OWN      = 2'd0,
    RATE_HALF     = 2'd1,
    RATE_QUARTER  = 2'd2,
    RATE_QUARTER2 = 2'd3
  } rate_sel_e;

  // Last count value of the shared-strobe divider for a rate select
  function automatic logic [1:0] rate_last(input logic [1:0] sel);
    return (sel == RATE_HALF) ? 2'd1 : 2'd3;
  endfunction
endpackage

// File: rtl/ppb_strobe_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser with rising-edge pulse output.
module ppb_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      rise  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-1:0], strobe};
      rise  <= chain[STAGES-1] & ~chain[STAGES];
    end
  end

  // R2: a synchronised edge yields a single event cycle
  a_r2_single_event: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ppb_sdp_ram.sv
`timescale 1ns/1ps
// Simple dual-port RAM, registered read, block-RAM friendly.
module ppb_sdp_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ppb_load_ctrl.sv
`timescale 1ns/1ps
// Workspace fill, block hand-over to the engine, and input rate selection.
// N_PTS must be a power of two; the workspace holds 2*N_PTS samples.
module ppb_load_ctrl
  import ppb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int N_PTS = 16,
  localparam int AW   = $clog2(N_PTS),
  localparam int PW   = AW + 1,
  localparam int CW   = $clog2(N_PTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          own_ev,
  input  logic          shared_ev,
  input  logic [1:0]    rate_sel,
  input  logic [AW-1:0] overlap,
  input  logic          in_en,
  input  logic [DW-1:0] in_data,
  output logic          in_rdy,
  output logic          eng_start,
  output logic [PW-1:0] eng_base,
  output logic          eng_wait,
  input  logic          eng_done,
  input  logic [AW-1:0] eng_rd_addr,
  output logic [DW-1:0] eng_rd_data
);
  logic          shared, div_hit, smp_ev;
  logic [1:0]    div_cnt;
  logic [CW-1:0] avail, hop;
  logic [PW-1:0] wr_ptr, next_base, rd_pos;
  logic          xf_act, full, accept, go;

  // Input rate: own strobe, or every 2nd/4th shared strobe edge
  assign shared  = (rate_sel != RATE_OWN);
  assign div_hit = shared_ev && (div_cnt >= rate_last(rate_sel));
  assign smp_ev  = shared ? div_hit : own_ev;

  always_ff @(posedge clk) begin
    if (rst)                     div_cnt <= '0;
    else if (shared && shared_ev) div_cnt <= div_hit ? 2'd0 : div_cnt + 2'd1;
  end

  // Fill and hand-over
  assign full   = (avail == CW'(N_PTS));
  assign accept = smp_ev & in_en & ~full;
  assign go     = full & ~xf_act;
  assign hop    = CW'(N_PTS) - CW'(overlap);

  always_ff @(posedge clk) begin
    if (rst) begin
      avail     <= '0;
      wr_ptr    <= '0;
      next_base <= '0;
      xf_act    <= 1'b0;
      eng_start <= 1'b0;
      eng_base  <= '0;
    end else begin
      eng_start <= go;
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (go) begin
        avail     <= CW'(overlap);
        eng_base  <= next_base;
        next_base <= next_base + PW'(hop);
        xf_act    <= 1'b1;
      end else begin
        avail <= avail + CW'(accept);
        if (eng_done) xf_act <= 1'b0;
      end
    end
  end

  assign in_rdy   = ~full;
  assign eng_wait = full & xf_act;
  assign rd_pos   = eng_base + PW'(eng_rd_addr);

  ppb_sdp_ram #(.DW(DW), .DEPTH(2 * N_PTS)) ws_ram_i (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (wr_ptr),
    .wr_data (in_data),
    .rd_en   (1'b1),
    .rd_addr (rd_pos),
    .rd_data (eng_rd_data)
  );

  // R3: nothing is stored while the pending block is complete
  a_r3_hold_when_full: assert property (@(posedge clk) disable iff (rst)
    full |=> (wr_ptr == $past(wr_ptr)));
  // R4: the fill count never passes one block
  a_r4_fill_bound: assert property (@(posedge clk) disable iff (rst)
    avail <= CW'(N_PTS));
  // R4: start is a single-cycle pulse following a complete block
  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  a_r4_start_after_full: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(full));
  // R5: no start while a transform is still running
  a_r5_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    (xf_act && !eng_done) |=> !eng_start);
  // R7: a shared-strobe sample restarts the divider count
  a_r7_div_restart: assert property (@(posedge clk) disable iff (rst)
    (shared && accept) |=> (div_cnt == 2'd0));
endmodule

// File: rtl/ppb_dump_ctrl.sv
`timescale 1ns/1ps
// Output store: written by the engine, drained on the output strobe.
module ppb_dump_ctrl #(
  parameter int DW    = 16,
  parameter int N_PTS = 16,
  localparam int AW   = $clog2(N_PTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_ev,
  input  logic          out_en,
  input  logic          res_we,
  input  logic [AW-1:0] res_addr,
  input  logic [DW-1:0] res_data,
  input  logic          eng_done,
  output logic [DW-1:0] out_data,
  output logic          out_avail,
  output logic          ob_free
);
  logic          ob_full, pull;
  logic [AW-1:0] rd_idx;

  assign pull = out_ev & out_en & ob_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_full <= 1'b0;
      rd_idx  <= '0;
    end else begin
      if (pull) rd_idx <= rd_idx + 1'b1;
      if (eng_done && !ob_full)                        ob_full <= 1'b1;
      else if (pull && rd_idx == AW'(N_PTS - 1))       ob_full <= 1'b0;
    end
  end

  assign out_avail = ob_full;
  assign ob_free   = ~ob_full;

  ppb_sdp_ram #(.DW(DW), .DEPTH(N_PTS)) ob_ram_i (
    .clk     (clk),
    .wr_en   (res_we),
    .wr_addr (res_addr),
    .wr_data (res_data),
    .rd_en   (pull),
    .rd_addr (rd_idx),
    .rd_data (out_data)
  );

  // R8: the engine writes only into a free store
  a_r8_write_when_free: assert property (@(posedge clk) disable iff (rst)
    res_we |-> !ob_full);
  // R10: drain position moves only on an enabled output edge
  a_r10_idle_no_advance: assert property (@(posedge clk) disable iff (rst)
    !(out_ev && out_en) |=> $stable(rd_idx));
  // R9: the last drained word frees the store
  a_r9_last_frees: assert property (@(posedge clk) disable iff (rst)
    (pull && rd_idx == AW'(N_PTS - 1)) |=> !ob_full);
endmodule

// File: rtl/ppb_xform_buf_ctrl.sv
`timescale 1ns/1ps
// Top: strobe synchronisers, workspace loader and output drainer.
module ppb_xform_buf_ctrl #(
  parameter int DW          = 16,
  parameter int N_PTS       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(N_PTS),
  localparam int PW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    rate_sel,
  input  logic [AW-1:0] overlap,
  input  logic          in_stb,
  input  logic          in_en,
  input  logic [DW-1:0] in_data,
  output logic          in_rdy,
  input  logic          out_stb,
  input  logic          out_en,
  output logic [DW-1:0] out_data,
  output logic          out_avail,
  output logic          eng_start,
  output logic [PW-1:0] eng_base,
  output logic          eng_wait,
  input  logic          eng_done,
  input  logic [AW-1:0] eng_rd_addr,
  output logic [DW-1:0] eng_rd_data,
  input  logic          eng_res_we,
  input  logic [AW-1:0] eng_res_addr,
  input  logic [DW-1:0] eng_res_data,
  output logic          ob_free
);
  logic [1:0] stb_raw, stb_rise;
  assign stb_raw = {out_stb, in_stb};

  for (genvar gi = 0; gi < 2; gi++) begin : g_sync
    ppb_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst    (rst),
      .strobe (stb_raw[gi]),
      .rise   (stb_rise[gi])
    );
  end

  ppb_load_ctrl #(.DW(DW), .N_PTS(N_PTS)) load_i (
    .clk         (clk),
    .rst         (rst),
    .own_ev      (stb_rise[0]),
    .shared_ev   (stb_rise[1]),
    .rate_sel    (rate_sel),
    .overlap     (overlap),
    .in_en       (in_en),
    .in_data     (in_data),
    .in_rdy      (in_rdy),
    .eng_start   (eng_start),
    .eng_base    (eng_base),
    .eng_wait    (eng_wait),
    .eng_done    (eng_done),
    .eng_rd_addr (eng_rd_addr),
    .eng_rd_data (eng_rd_data)
  );

  ppb_dump_ctrl #(.DW(DW), .N_PTS(N_PTS)) dump_i (
    .clk       (clk),
    .rst       (rst),
    .out_ev    (stb_rise[1]),
    .out_en    (out_en),
    .res_we    (eng_res_we),
    .res_addr  (eng_res_addr),
    .res_data  (eng_res_data),
    .eng_done  (eng_done),
    .out_data  (out_data),
    .out_avail (out_avail),
    .ob_free   (ob_free)
  );
endmodule

// File: tb/ppb_xform_buf_ctrl_tb_top.sv
`timescale 1ns/1ps
module ppb_xform_buf_ctrl_tb_top;
  localparam int DW = 16, N = 16, AW = 4, PW = 5, WS = 2 * N;

  logic          clk = 1'b0, rst = 1'b1;
  logic [1:0]    rate_sel = '0;
  logic [AW-1:0] overlap = '0;
  logic          in_stb = 0, in_en = 0, out_stb = 0, out_en = 0;
  logic [DW-1:0] in_data = '0;
  logic          in_rdy, out_avail, eng_start, eng_wait, ob_free;
  logic [DW-1:0] out_data, eng_rd_data;
  logic [PW-1:0] eng_base;
  logic          eng_done = 0, eng_res_we = 0;
  logic [AW-1:0] eng_rd_addr = '0, eng_res_addr = '0;
  logic [DW-1:0] eng_res_data = '0;

  ppb_xform_buf_ctrl #(.DW(DW), .N_PTS(N)) dut_i (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .overlap(overlap),
    .in_stb(in_stb), .in_en(in_en), .in_data(in_data), .in_rdy(in_rdy),
    .out_stb(out_stb), .out_en(out_en), .out_data(out_data), .out_avail(out_avail),
    .eng_start(eng_start), .eng_base(eng_base), .eng_wait(eng_wait), .eng_done(eng_done),
    .eng_rd_addr(eng_rd_addr), .eng_rd_data(eng_rd_data), .eng_res_we(eng_res_we),
    .eng_res_addr(eng_res_addr), .eng_res_data(eng_res_data), .ob_free(ob_free)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, start_cnt = 0;
  logic [PW-1:0] last_base = '0;
  always @(negedge clk) if (!rst && eng_start) begin start_cnt++; last_base = eng_base; end

  // Bench model
  logic [DW-1:0] smp [4096];
  logic [DW-1:0] res_q [$];
  int nacc = 0, blk_start = 0, cur_blk = 0, exp_starts = 0, ovl_m = 0, dcnt = 0;
  bit m_act = 0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic strobe(input bit on_out);
    @(negedge clk);
    if (on_out) out_stb = 1'b1; else in_stb = 1'b1;
    repeat (3) @(negedge clk);
    out_stb = 1'b0; in_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit m_full();
    return (nacc - blk_start) == N;
  endfunction

  task automatic model_go();
    if (m_full() && !m_act) begin
      m_act = 1; exp_starts++;
      cur_blk = blk_start;
      blk_start += N - ovl_m;
      chk(start_cnt == exp_starts, "R4 start pulse count", start_cnt, exp_starts);
      chk(int'(last_base) == cur_blk % WS, "R4 block base", last_base, cur_blk % WS);
    end
  endtask

  task automatic set_overlap(input int v);
    overlap = AW'(v); ovl_m = v;
  endtask

  task automatic feed_own(input logic [DW-1:0] d);
    bit take;
    take = (rate_sel == 2'd0) && in_en && !m_full();
    in_data = d;
    strobe(1'b0);
    if (take) begin smp[nacc] = d; nacc++; end
    model_go();
  endtask

  task automatic feed_shared(input logic [DW-1:0] d);
    bit hit, take;
    int lim;
    hit = 0;
    if (rate_sel != 2'd0) begin
      lim = (rate_sel == 2'd1) ? 1 : 3;
      hit = (dcnt >= lim);
      dcnt = hit ? 0 : dcnt + 1;
    end
    take = hit && in_en && !m_full();
    in_data = d;
    strobe(1'b1);
    if (take) begin smp[nacc] = d; nacc++; end
    model_go();
  endtask

  task automatic drain();
    logic [1:0] saved;
    logic [DW-1:0] e;
    saved = rate_sel; rate_sel = 2'd0; out_en = 1'b1;
    for (int i = 0; i < N; i++) begin
      strobe(1'b1);
      e = res_q.pop_front();
      chk(out_data == e, "R9 drained word order", out_data, e);
    end
    out_en = 1'b0;
    chk(out_avail == 1'b0, "R9 store empty after drain", out_avail, 0);
    chk(ob_free == 1'b1, "R9 store free after drain", ob_free, 1);
    rate_sel = saved;
  endtask

  task automatic finish_block();
    logic [DW-1:0] r;
    for (int i = 0; i < N; i++) begin
      @(negedge clk) eng_rd_addr = AW'(i);
      @(negedge clk);
      chk(eng_rd_data == smp[cur_blk + i], "R6 R2 block read", eng_rd_data, smp[cur_blk + i]);
    end
    if (!ob_free) drain();
    for (int i = 0; i < N; i++) begin
      r = ~smp[cur_blk + i] ^ DW'(i * 3);
      @(negedge clk);
      eng_res_we = 1'b1; eng_res_addr = AW'(i); eng_res_data = r;
      res_q.push_back(r);
    end
    @(negedge clk) eng_res_we = 1'b0; eng_done = 1'b1;
    @(negedge clk) eng_done = 1'b0;
    m_act = 0;
    repeat (3) @(negedge clk);
    chk(out_avail == 1'b1, "R8 results available", out_avail, 1);
    chk(ob_free == 1'b0, "R8 store busy", ob_free, 0);
    model_go();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_rdy == 1, "R1 in_rdy", in_rdy, 1);
    chk(out_avail == 0, "R1 out_avail", out_avail, 0);
    chk(ob_free == 1, "R1 ob_free", ob_free, 1);
    chk(eng_start == 0, "R1 eng_start", eng_start, 0);
    chk(eng_wait == 0, "R1 eng_wait", eng_wait, 0);
    chk(eng_base == 0, "R1 eng_base", eng_base, 0);

    // Block A, then block B while A is transformed
    in_en = 1'b1;
    repeat (N) feed_own(DW'($urandom));
    repeat (N) feed_own(DW'($urandom));
    chk(eng_wait == 1, "R5 wait while busy", eng_wait, 1);
    chk(in_rdy == 0, "R5 not ready while full", in_rdy, 0);
    feed_own(16'hDEAD);
    chk(start_cnt == 1, "R5 no start while busy", start_cnt, 1);
    finish_block();

    // R10: unenabled output edges consume nothing
    out_en = 1'b0;
    repeat (3) strobe(1'b1);
    chk(out_avail == 1, "R10 results kept", out_avail, 1);
    drain();

    // R3: in_en low ignored one sample before full
    repeat (N - 1) feed_own(DW'($urandom));
    in_en = 1'b0;
    feed_own(16'hBEEF);
    chk(in_rdy == 1, "R3 disabled edge ignored", in_rdy, 1);
    in_en = 1'b1;
    feed_own(DW'($urandom));
    chk(in_rdy == 0, "R5 full after last sample", in_rdy, 0);
    set_overlap(4);
    finish_block();

    // R7: shared strobe /2, own strobe ignored
    rate_sel = 2'd1;
    repeat (3) feed_own(DW'($urandom));
    while (!m_full()) feed_shared(DW'($urandom));
    chk(eng_wait == 1, "R7 block filled by shared /2", eng_wait, 1);
    finish_block();

    // R7: shared strobe /4 and the alternate /4 code
    rate_sel = 2'd2; set_overlap(8);
    while (!m_full()) feed_shared(DW'($urandom));
    finish_block();
    rate_sel = 2'd3; set_overlap(0);
    while (!m_full()) feed_shared(DW'($urandom));
    finish_block();

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      set_overlap($urandom_range(0, N - 1));
      rate_sel = 2'($urandom_range(0, 3));
      while (!m_full()) begin
        in_en = ($urandom_range(0, 4) != 0);
        if (rate_sel == 2'd0) feed_own(DW'($urandom));
        else if ($urandom_range(0, 5) == 0) feed_own(DW'($urandom));
        else feed_shared(DW'($urandom));
      end
      in_en = 1'b1;
      finish_block();
    end
    if (m_act) finish_block();
    if (res_q.size() != 0) drain();
    report();
  end
endmodule